// File: doc/BRIEF.md
# MIDI UART Command Port

This block is a byte-wide host port in front of a serial MIDI transmitter and receiver. The host sees two byte locations. Location 0 is the data register: a write sends a byte to the serial line, and a read takes the oldest received byte. Location 1 is shared: a write is a command, and a read returns two active-low ready flags plus a sticky overrun flag. Two interrupt requests, each with its own enable, report that received data is waiting and that the transmitter can take a byte.

Only two command values do anything. One returns the port to its idle command state. The other enters UART pass-through mode. Every accepted command places an acknowledge byte 0xFE in the receive path, so the host sees it the same way as received data. The serial side uses 8 data bits, no parity and one stop bit. `CLK_DIV` sets the number of clock cycles per bit; its default of 8000 gives 31250 baud from a 250 MHz clock. Received bytes go into a FIFO of `FIFO_DEPTH` entries, 4 by default.

If an acknowledge and a received serial byte reach the FIFO in the same cycle, the acknowledge wins. The serial byte is then discarded and the overrun flag is set.

Top module: `midi_cmd_port`

## Requirements
- R1: After reset the status byte is 0x80, the port is in command mode, `midi_out` is high, and `tx_irq` equals `tx_irq_en` while `rx_irq` is 0.
- R2: `host_addr`=1 reads the status byte. Bit 7 is 0 when a receive entry is available. Bit 6 is 0 when the transmit holding register is empty. Bit 5 is the overrun flag. Bits 4:0 are 0.
- R3: Command 0xFF empties the receive FIFO, clears overrun, discards a byte waiting in the holding register and leaves UART mode. It then enqueues 0xFE, so the status byte reads 0x00 while a frame already on the line is allowed to finish.
- R4: Command 0x3F enters UART mode and enqueues 0xFE, which drives status bit 7 to 0 on the next cycle.
- R5: Any other command value is ignored. It produces no acknowledge and does not change the mode.
- R6: A read of `host_addr`=0 returns the oldest receive entry and removes it. When the FIFO is empty the read returns 0xFF and changes nothing. Status bit 7 returns to 1 once the FIFO is empty.
- R7: The FIFO keeps arrival order and holds `FIFO_DEPTH` entries. An entry arriving while it is full is dropped and sets status bit 5. That bit stays set until a 0xFF command.
- R8: In UART mode a data write made while status bit 6 is 0 is sent on `midi_out` as a start bit (0), 8 data bits LSB first and a stop bit (1), each `CLK_DIV` cycles long. A data write made while bit 6 is 1 is ignored.
- R9: In command mode, data writes are not transmitted and serial bytes arriving on `midi_in` are discarded.
- R10: The receiver samples each bit near its middle. A frame whose stop bit is 0 is discarded, and the receiver waits for the line to go high before looking for a new start bit.
- R11: `rx_irq` = `rx_irq_en` AND (a receive entry is available). `tx_irq` = `tx_irq_en` AND (the holding register is empty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 1 | 0 = data register, 1 = command/status |
| host_wdata | input | 8 | Write data or command byte |
| host_rdata | output | 8 | Read data (combinational on `host_addr`) |
| tx_irq_en | input | 1 | Enable for the transmit-ready interrupt |
| rx_irq_en | input | 1 | Enable for the data-available interrupt |
| tx_irq | output | 1 | Transmit holding register empty |
| rx_irq | output | 1 | Receive data available |
| midi_in | input | 1 | Serial MIDI input, idle high |
| midi_out | output | 1 | Serial MIDI output, idle high |

## Verification
Assertions check on every cycle that:
- an accepted command makes status bit 7 read 0 on the next cycle;
- 0xFF leaves exactly the acknowledge in the FIFO with overrun clear;
- ignored commands keep the mode;
- nothing reaches the holding register in command mode;
- a full-FIFO drop or an empty pop leaves the count unchanged;
- a waiting byte moves into the idle shifter on the next cycle.

Only the bench scenarios can show the serial behaviour end to end: bit order and timing on `midi_out`, decoding of frames driven on `midi_in`, discarding a frame with a bad stop bit, and the order of bytes read back after an overrun. The bench's queue model checks the status flags and `rx_irq` on every quiet cycle.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;

  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] CMD_UART   = 8'h3F;
  localparam logic [7:0] ACK_BYTE   = 8'hFE;
  localparam logic [7:0] EMPTY_READ = 8'hFF;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_DO_RESET,
    CMD_DO_UART
  } cmd_kind_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAIT_HIGH
  } rx_state_e;

  function automatic cmd_kind_e decode_cmd(input logic [7:0] code);
    if (code == CMD_RESET) return CMD_DO_RESET;
    if (code == CMD_UART)  return CMD_DO_UART;
    return CMD_NONE;
  endfunction

  // Active-low ready flags in bits 7 and 6, sticky overrun in bit 5.
  function automatic logic [7:0] pack_status(input logic rx_avail,
                                             input logic tx_ready,
                                             input logic ovr);
    return {~rx_avail, ~tx_ready, ovr, 5'b0};
  endfunction

endpackage

// File: rtl/midi_rx_fifo.sv
module midi_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         dropped
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop & ~empty;
  assign do_push = push & (~full | do_pop);
  assign dropped = push & ~flush & ~do_push;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= push ? step('0) : '0;
      cnt    <= push ? CW'(1) : '0;
    end else begin
      if (do_pop)  rd_ptr <= step(rd_ptr);
      if (do_push) wr_ptr <= step(wr_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (flush && push)  mem[0]      <= push_data;
    else if (!flush && do_push) mem[wr_ptr] <= push_data;
  end

  // R7
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> (cnt == $past(cnt)));

  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/midi_uart_tx.sv
module midi_uart_tx #(
  parameter int CLK_DIV = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic       clear,
  output logic       hold_empty,
  output logic       line_out
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          hold_v;
  logic [7:0]    hold_d;
  logic          busy;
  logic [9:0]    shreg;
  logic [3:0]    idx;
  logic [DW-1:0] div;

  assign hold_empty = ~hold_v;
  assign line_out   = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      busy   <= 1'b0;
      shreg  <= '1;
      idx    <= '0;
      div    <= '0;
    end else begin
      if (clear) begin
        hold_v <= 1'b0;
      end else if (load && !hold_v) begin
        hold_v <= 1'b1;
        hold_d <= load_data;
      end else if (hold_v && !busy) begin
        hold_v <= 1'b0;
        busy   <= 1'b1;
        shreg  <= {1'b1, hold_d, 1'b0};
        idx    <= '0;
        div    <= '0;
      end
      if (busy) begin
        if (div == DW'(CLK_DIV - 1)) begin
          div   <= '0;
          shreg <= {1'b1, shreg[9:1]};
          if (idx == 4'd9) busy <= 1'b0;
          else             idx  <= idx + 4'd1;
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  // R8
  hold_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !busy && !clear) |=> (busy && !hold_v));

endmodule

// File: rtl/midi_uart_rx.sv
module midi_uart_rx
  import midi_port_pkg::*;
#(
  parameter int CLK_DIV = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = (CLK_DIV > 1) ? CLK_DIV / 2 : 1;

  logic          s1, s2;
  rx_state_e     state;
  logic [DW-1:0] div;
  logic [2:0]    idx;
  logic [7:0]    shreg;

  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1         <= 1'b1;
      s2         <= 1'b1;
      state      <= RX_IDLE;
      div        <= '0;
      idx        <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
    end else begin
      s1         <= line_in;
      s2         <= s1;
      byte_valid <= 1'b0;
      case (state)
        RX_IDLE: if (!s2) begin
          state <= RX_START;
          div   <= '0;
        end
        RX_START: begin
          if (div == DW'(HALF - 1)) begin
            div   <= '0;
            idx   <= '0;
            state <= s2 ? RX_IDLE : RX_DATA;
          end else div <= div + 1'b1;
        end
        RX_DATA: begin
          if (div == DW'(CLK_DIV - 1)) begin
            div   <= '0;
            shreg <= {s2, shreg[7:1]};
            if (idx == 3'd7) state <= RX_STOP;
            else             idx   <= idx + 3'd1;
          end else div <= div + 1'b1;
        end
        RX_STOP: begin
          if (div == DW'(CLK_DIV - 1)) begin
            div <= '0;
            if (s2) begin
              byte_valid <= 1'b1;
              state      <= RX_IDLE;
            end else begin
              state <= RX_WAIT_HIGH;
            end
          end else div <= div + 1'b1;
        end
        RX_WAIT_HIGH: if (s2) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R10
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

endmodule

// File: rtl/midi_cmd_port.sv
module midi_cmd_port
  import midi_port_pkg::*;
#(
  parameter int CLK_DIV    = 8000,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       tx_irq_en,
  input  logic       rx_irq_en,
  output logic       tx_irq,
  output logic       rx_irq,
  input  logic       midi_in,
  output logic       midi_out
);
  // Named internal events, visible to the assertions below.
  logic       data_wr, data_rd, cmd_wr, cmd_ok, cmd_rst;
  cmd_kind_e  cmd_kind;
  logic       rx_valid, rx_take, clash;
  logic [7:0] rx_byte;
  logic       fifo_push, fifo_empty, fifo_full, fifo_drop;
  logic [7:0] fifo_data, fifo_head, host_status;
  logic       tx_load, tx_hold_empty;
  logic       uart_mode, overrun;

  assign data_wr  = host_sel &  host_wr & ~host_addr;
  assign data_rd  = host_sel & ~host_wr & ~host_addr;
  assign cmd_wr   = host_sel &  host_wr &  host_addr;
  assign cmd_kind = decode_cmd(host_wdata);
  assign cmd_ok   = cmd_wr & (cmd_kind != CMD_NONE);
  assign cmd_rst  = cmd_wr & (cmd_kind == CMD_DO_RESET);

  assign rx_take   = rx_valid & uart_mode;
  assign clash     = rx_take & cmd_ok;
  assign fifo_push = cmd_ok | rx_take;
  assign fifo_data = cmd_ok ? ACK_BYTE : rx_byte;
  assign tx_load   = data_wr & uart_mode & tx_hold_empty;

  assign host_status = pack_status(~fifo_empty, tx_hold_empty, overrun);
  assign host_rdata  = host_addr ? host_status
                                 : (fifo_empty ? EMPTY_READ : fifo_head);
  assign rx_irq = rx_irq_en & ~fifo_empty;
  assign tx_irq = tx_irq_en & tx_hold_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uart_mode <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (cmd_rst)                            uart_mode <= 1'b0;
      else if (cmd_ok)                        uart_mode <= 1'b1;
      if (cmd_rst)                            overrun   <= 1'b0;
      else if (fifo_drop || clash)            overrun   <= 1'b1;
    end
  end

  midi_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(cmd_rst), .push(fifo_push),
    .push_data(fifo_data), .pop(data_rd), .head(fifo_head),
    .empty(fifo_empty), .full(fifo_full), .dropped(fifo_drop)
  );

  midi_uart_tx #(.CLK_DIV(CLK_DIV)) tx_i (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(host_wdata),
    .clear(cmd_rst), .hold_empty(tx_hold_empty), .line_out(midi_out)
  );

  midi_uart_rx #(.CLK_DIV(CLK_DIV)) rx_i (
    .clk(clk), .rst_n(rst_n), .line_in(midi_in),
    .byte_valid(rx_valid), .byte_data(rx_byte)
  );

  // R4
  ack_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> !host_status[7]);

  // R3
  reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (!fifo_empty && fifo_head == ACK_BYTE && !host_status[5] && !uart_mode));

  // R5
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_ok) |=> $stable(uart_mode));

  // R9
  cmd_mode_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_mode |-> tx_hold_empty);

  // R7
  full_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && rx_take && !data_rd && !cmd_ok) |=> host_status[5]);

endmodule

// File: tb/midi_cmd_port_tb_top.sv
`timescale 1ns/1ps
module midi_cmd_port_tb_top;
  localparam int DIV = 16;
  localparam int FD  = 4;

  logic clk = 0, rst_n = 0;
  logic host_sel = 0, host_wr = 0, host_addr = 1;
  logic [7:0] host_wdata = 0;
  wire  [7:0] host_rdata;
  logic tx_irq_en = 1, rx_irq_en = 0;
  wire  tx_irq, rx_irq, midi_out;
  logic midi_in = 1;

  midi_cmd_port #(.CLK_DIV(DIV), .FIFO_DEPTH(FD)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .midi_in(midi_in), .midi_out(midi_out)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0, cmp_on = 0;
  logic [7:0] mq[$];
  logic [7:0] tx_seen[$];
  bit m_ovr = 0, m_mode = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Reference model compared on every quiet clock (R2, R7, R11).
  always @(posedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      chk(rx_irq == (rx_irq_en && mq.size() > 0), "R11 rx_irq per cycle",
          rx_irq, (rx_irq_en && mq.size() > 0));
      if (host_addr) begin
        chk(host_rdata[7] == (mq.size() == 0), "R2 status bit7 per cycle",
            host_rdata[7], (mq.size() == 0));
        chk(host_rdata[5] == m_ovr, "R7 overrun bit per cycle", host_rdata[5], m_ovr);
        chk(host_rdata[4:0] == 5'd0, "R2 low status bits", host_rdata[4:0], 0);
      end
    end
  end

  // Independent serial decoder on midi_out.
  initial begin
    logic [7:0] b;
    forever begin
      @(posedge clk);
      if (rst_n && midi_out == 1'b0) begin
        repeat (DIV/2) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(posedge clk);
          b[i] = midi_out;
        end
        repeat (DIV) @(posedge clk);
        chk(midi_out == 1'b1, "R8 stop bit level", midi_out, 1);
        tx_seen.push_back(b);
      end
    end
  end

  task automatic hwrite(input bit a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk);
    if (a) begin
      if (d == 8'hFF) begin
        mq.delete(); m_ovr = 0; m_mode = 0; mq.push_back(8'hFE);
      end else if (d == 8'h3F) begin
        m_mode = 1;
        if (mq.size() < FD) mq.push_back(8'hFE); else m_ovr = 1;
      end
    end
    @(negedge clk);
    host_sel = 0; host_wr = 0; host_addr = 1;
  endtask

  task automatic rd_pop(input string tag);
    logic [7:0] exp, got;
    exp = (mq.size() > 0) ? mq[0] : 8'hFF;
    @(negedge clk);
    host_sel = 1; host_wr = 0; host_addr = 0;
    #1 got = host_rdata;
    @(posedge clk);
    if (mq.size() > 0) void'(mq.pop_front());
    @(negedge clk);
    host_sel = 0; host_addr = 1;
    chk(got == exp, tag, got, exp);
  endtask

  task automatic st_chk(input logic [7:0] exp, input string tag);
    @(negedge clk);
    #1 chk(host_rdata == exp, tag, host_rdata, exp);
  endtask

  task automatic send_serial(input logic [7:0] b, input bit good_stop);
    cmp_on = 0;
    @(negedge clk);
    midi_in = 0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_in = b[i];
      repeat (DIV) @(negedge clk);
    end
    midi_in = good_stop;
    repeat (DIV) @(negedge clk);
    midi_in = 1;
    repeat (DIV) @(negedge clk);
    if (good_stop && m_mode) begin
      if (mq.size() < FD) mq.push_back(b); else m_ovr = 1;
    end
    cmp_on = 1;
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    st_chk(8'h80, "R1 status after reset");
    chk(midi_out == 1'b1, "R1 line idle", midi_out, 1);
    chk(tx_irq == 1'b1, "R1 tx_irq with enable", tx_irq, 1);
    chk(rx_irq == 1'b0, "R1 rx_irq idle", rx_irq, 0);

    // R9 command mode: data write not sent, serial byte discarded
    hwrite(0, 8'h55);
    repeat (300) @(posedge clk);
    chk(tx_seen.size() == 0, "R9 no transmit in command mode", tx_seen.size(), 0);
    send_serial(8'h42, 1);
    st_chk(8'h80, "R9 serial byte discarded in command mode");

    // R5 unknown command ignored, mode unchanged
    hwrite(1, 8'h12);
    st_chk(8'h80, "R5 no ack for unknown command");
    send_serial(8'h43, 1);
    st_chk(8'h80, "R5 mode unchanged after unknown command");

    // R4 enter UART mode, R6 ack pop and empty read
    hwrite(1, 8'h3F);
    st_chk(8'h00, "R4 ack makes bit7 low");
    rd_pop("R6 read returns ack 0xFE");
    st_chk(8'h80, "R6 bit7 back to 1 when empty");
    rd_pop("R6 empty read returns 0xFF");
    st_chk(8'h80, "R6 empty read changes nothing");

    // R10 R7 R11 reception order, rx irq gating
    send_serial(8'h11, 1);
    chk(rx_irq == 1'b0, "R11 rx_irq gated off", rx_irq, 0);
    rx_irq_en = 1;
    send_serial(8'h22, 1);
    send_serial(8'h33, 1);
    chk(rx_irq == 1'b1, "R11 rx_irq with data", rx_irq, 1);
    rd_pop("R10 first received byte");
    rd_pop("R7 order second");
    rd_pop("R7 order third");
    chk(rx_irq == 1'b0, "R11 rx_irq after drain", rx_irq, 0);

    // R10 bad stop bit discarded
    send_serial(8'h5A, 0);
    st_chk(8'h80, "R10 framing error discarded");
    send_serial(8'h6B, 1);
    rd_pop("R10 receiver recovers after framing error");

    // R7 overrun: five bytes into four entries
    for (int k = 0; k < 5; k++) send_serial(8'hA0 + 8'(k), 1);
    st_chk(8'h20, "R7 full with overrun flag");
    for (int k = 0; k < 4; k++) rd_pop("R7 kept entries after overrun");
    st_chk(8'hA0, "R7 overrun sticky after drain");

    // R8 transmit: A, B accepted, C ignored while holding full
    tx_seen.delete();
    hwrite(0, 8'hA5);
    hwrite(0, 8'h3C);
    st_chk(8'hE0, "R8 bit6 high while holding full");
    chk(tx_irq == 1'b0, "R11 tx_irq low while holding full", tx_irq, 0);
    hwrite(0, 8'hC3);
    repeat (500) @(posedge clk);
    chk(tx_seen.size() == 2, "R8 frame count", tx_seen.size(), 2);
    if (tx_seen.size() == 2) begin
      chk(tx_seen[0] == 8'hA5, "R8 first frame", tx_seen[0], 8'hA5);
      chk(tx_seen[1] == 8'h3C, "R8 second frame", tx_seen[1], 8'h3C);
    end
    chk(tx_irq == 1'b1, "R11 tx_irq after drain", tx_irq, 1);

    // R3 reset command with data, overrun and a held byte
    send_serial(8'h77, 1);
    tx_seen.delete();
    hwrite(0, 8'h11);
    hwrite(0, 8'h22);
    hwrite(1, 8'hFF);
    st_chk(8'h00, "R3 status after reset command");
    rd_pop("R3 only ack remains");
    st_chk(8'h80, "R3 fifo empty after ack read");
    repeat (500) @(posedge clk);
    chk(tx_seen.size() == 1, "R3 held byte discarded", tx_seen.size(), 1);
    if (tx_seen.size() == 1)
      chk(tx_seen[0] == 8'h11, "R3 frame in flight finished", tx_seen[0], 8'h11);
    hwrite(0, 8'h33);
    repeat (300) @(posedge clk);
    chk(tx_seen.size() == 1, "R3 command mode after reset", tx_seen.size(), 1);

    done = 1;
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule